// File: doc/BRIEF.md
# Programmable Input Capture Cell Array

This block conditions a set of pin inputs before they reach a logic array. Each cell holds one pin bit and can act as an edge-triggered D register, a level-sensitive D latch, or a plain flow-through path. A cell's enable/clock comes from one of two places. In synchronous mode it is a shared global enable/clock input that every such cell sees. In asynchronous mode it is the cell's own product-term input. Each cell is configured on its own, so synchronous and asynchronous cells, and latch and register cells, can be mixed in the same array.

All inputs are sampled on the system clock `clk`. The enable/clock of a cell is the value selected for it, and an edge of that enable means a change between two consecutive samples. Register cells store the pin on the falling edge of their enable. Latch cells pass the pin while their enable is high and close when it falls. Flow-through is a latch cell whose product term is tied high. Each cell drives a true and a complement output to the array, and both come straight from flip-flops. Reset is synchronous and active high. During reset, latch cells load the pin on every cycle. Register cells keep whatever they hold, which is undefined after power-up until their first capture.

Top module: `incap_array`

## Requirements
- R1: A register cell (`cfg_latch[i]`=0) whose enable was sampled high on one clock and is sampled low on the next takes, on that next clock, the pin value sampled on that clock. The new value appears on `dat_t[i]` right after that edge.
- R2: A cell with `cfg_async[i]`=1 takes its enable from `pterm[i]`, and `gclk_en` has no effect on it. A cell with `cfg_async[i]`=0 takes its enable from `gclk_en`, and `pterm[i]` has no effect on it.
- R3: A latch cell (`cfg_latch[i]`=1) whose enable is sampled high on a clock loads the pin sampled on that clock. The value appears on `dat_t[i]` right after that edge, so the output follows the pin one cycle late.
- R4: A register cell keeps its value while its enable stays low, while it stays high, and when it rises. A latch cell keeps its value on every clock where its enable is sampled low.
- R5: An asynchronous latch cell opens and closes on its own `pterm[i]`, independently of the other cells.
- R6: An asynchronous latch cell whose `pterm[i]` is held at 1 is a flow-through path: `dat_t[i]` equals the pin of the previous cycle whatever `gclk_en` does.
- R7: Once a cell holds defined data, `dat_c[i]` is always the inverse of `dat_t[i]`.
- R8: While `rst` is 1, latch cells load the pin on every cycle and register cells keep their value. Reset clears the enable history, so the first enable sample taken after reset can never count as a falling edge.
- R9: Cells with different `cfg_latch` and `cfg_async` settings work side by side in the same cycles without affecting one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | N_CELLS | Pin data, one bit per cell |
| gclk_en | input | 1 | Global enable/clock shared by synchronous cells |
| pterm | input | N_CELLS | Per-cell product-term enable/clock |
| cfg_latch | input | N_CELLS | Per cell: 1 = latch, 0 = register |
| cfg_async | input | N_CELLS | Per cell: 1 = enable from `pterm`, 0 = enable from `gclk_en` |
| dat_t | output | N_CELLS | True data to the array |
| dat_c | output | N_CELLS | Complement data to the array |

## Verification
The assertions assume that every input is already synchronous to `clk`. They also assume that configuration bits do not change between the cycle that triggers a property and the cycle that checks it. Each property therefore lets a cycle pass unchecked if `cfg_latch` or `cfg_async` changed at that moment. The complement check waits until the checker has seen a cell receive defined data, which means reset for a latch cell and the first falling edge for a register cell. The stimulus drives all inputs on the falling clock edge. It changes configuration only at the start of a scenario. It also gives each register cell a capture edge before its output is compared, so the undefined power-up contents never reach a check.

// File: rtl/incap_pkg.sv
package incap_pkg;

  typedef enum logic {
    STORE_REG   = 1'b0,
    STORE_LATCH = 1'b1
  } store_kind_e;

  typedef enum logic {
    SRC_GLOBAL = 1'b0,
    SRC_TERM   = 1'b1
  } en_src_e;

endpackage

// File: rtl/incap_en_sel.sv
module incap_en_sel
  import incap_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    glob_en,
  input  logic    term_en,
  input  en_src_e src,
  output logic    en_now,
  output logic    en_fall
);

  logic en_hist_q;

  assign en_now = (src == SRC_TERM) ? term_en : glob_en;

  // History cleared in reset so the first sample afterwards is never a fall.
  always_ff @(posedge clk) begin
    if (rst) en_hist_q <= 1'b0;
    else     en_hist_q <= en_now;
  end

  assign en_fall = en_hist_q & ~en_now;

endmodule

// File: rtl/incap_store.sv
module incap_store
  import incap_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        pin,
  input  logic        en_now,
  input  logic        en_fall,
  input  store_kind_e kind,
  output logic        q_t,
  output logic        q_c
);

  logic nxt;

  always_comb begin
    nxt = q_t;
    if (kind == STORE_LATCH) begin
      if (rst || en_now) nxt = pin;
    end else begin
      if (!rst && en_fall) nxt = pin;
    end
  end

  // Register cells are deliberately left without a reset value.
  always_ff @(posedge clk) begin
    q_t <= nxt;
    q_c <= ~nxt;
  end

endmodule

// File: rtl/incap_cell.sv
module incap_cell
  import incap_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic glob_en,
  input  logic term_en,
  input  logic use_latch,
  input  logic use_term,
  output logic q_t,
  output logic q_c
);

  logic en_now;
  logic en_fall;

  incap_en_sel u_sel (
    .clk     (clk),
    .rst     (rst),
    .glob_en (glob_en),
    .term_en (term_en),
    .src     (en_src_e'(use_term)),
    .en_now  (en_now),
    .en_fall (en_fall)
  );

  incap_store u_store (
    .clk     (clk),
    .rst     (rst),
    .pin     (pin),
    .en_now  (en_now),
    .en_fall (en_fall),
    .kind    (store_kind_e'(use_latch)),
    .q_t     (q_t),
    .q_c     (q_c)
  );

endmodule

// File: rtl/incap_array.sv
module incap_array #(
  parameter int N_CELLS = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_CELLS-1:0] pin_in,
  input  logic               gclk_en,
  input  logic [N_CELLS-1:0] pterm,
  input  logic [N_CELLS-1:0] cfg_latch,
  input  logic [N_CELLS-1:0] cfg_async,
  output logic [N_CELLS-1:0] dat_t,
  output logic [N_CELLS-1:0] dat_c
);

  for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
    incap_cell u_cell (
      .clk       (clk),
      .rst       (rst),
      .pin       (pin_in[i]),
      .glob_en   (gclk_en),
      .term_en   (pterm[i]),
      .use_latch (cfg_latch[i]),
      .use_term  (cfg_async[i]),
      .q_t       (dat_t[i]),
      .q_c       (dat_c[i])
    );
  end

endmodule

// File: rtl/incap_array_chk.sv
module incap_array_chk #(
  parameter int N_CELLS = 4
) (
  input logic               clk,
  input logic               rst,
  input logic [N_CELLS-1:0] pin_in,
  input logic               gclk_en,
  input logic [N_CELLS-1:0] pterm,
  input logic [N_CELLS-1:0] cfg_latch,
  input logic [N_CELLS-1:0] cfg_async,
  input logic [N_CELLS-1:0] dat_t,
  input logic [N_CELLS-1:0] dat_c
);

  for (genvar i = 0; i < N_CELLS; i++) begin : g_chk
    logic sel;
    logic prev_q;
    logic fall;
    logic defined_q = 1'b0;

    assign sel  = cfg_async[i] ? pterm[i] : gclk_en;
    assign fall = prev_q & ~sel;

    always_ff @(posedge clk) begin
      if (rst) prev_q <= 1'b0;
      else     prev_q <= sel;
      defined_q <= defined_q | (cfg_latch[i] & (rst | sel)) |
                   (~cfg_latch[i] & ~rst & fall);
    end

    AST_REG_CAPTURE: assert property (@(posedge clk) disable iff (rst)
      (!cfg_latch[i] && fall) |=> (!$stable(cfg_latch[i]) || !$stable(cfg_async[i]) || dat_t[i] == $past(pin_in[i]))); // R1

    AST_REG_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!cfg_latch[i] && !fall) |=> (!$stable(cfg_latch[i]) || !$stable(cfg_async[i]) || $stable(dat_t[i]))); // R4

    AST_LATCH_OPEN: assert property (@(posedge clk) disable iff (rst)
      (cfg_latch[i] && sel) |=> (!$stable(cfg_latch[i]) || !$stable(cfg_async[i]) || dat_t[i] == $past(pin_in[i]))); // R3

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
      (cfg_latch[i] && !sel) |=> (!$stable(cfg_latch[i]) || !$stable(cfg_async[i]) || $stable(dat_t[i]))); // R4

    AST_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
      defined_q |-> (dat_c[i] == ~dat_t[i])); // R7
  end

endmodule

bind incap_array incap_array_chk #(.N_CELLS(N_CELLS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .pin_in    (pin_in),
  .gclk_en   (gclk_en),
  .pterm     (pterm),
  .cfg_latch (cfg_latch),
  .cfg_async (cfg_async),
  .dat_t     (dat_t),
  .dat_c     (dat_c)
);

// File: tb/incap_array_tb.sv
module incap_array_tb;

  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst;
  logic [N-1:0] pin_in;
  logic         gclk_en;
  logic [N-1:0] pterm;
  logic [N-1:0] cfg_latch;
  logic [N-1:0] cfg_async;
  logic [N-1:0] dat_t;
  logic [N-1:0] dat_c;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  incap_array #(.N_CELLS(N)) u_dut (
    .clk       (clk),
    .rst       (rst),
    .pin_in    (pin_in),
    .gclk_en   (gclk_en),
    .pterm     (pterm),
    .cfg_latch (cfg_latch),
    .cfg_async (cfg_async),
    .dat_t     (dat_t),
    .dat_c     (dat_c)
  );

  task automatic chk(input string req, input logic [N-1:0] exp);
    n_checks++;
    if (dat_t !== exp) begin
      n_fail++;
      $display("FAIL %s: dat_t actual %b expected %b", req, dat_t, exp);
    end
    n_checks++;
    if (dat_c !== ~exp) begin
      n_fail++;
      $display("FAIL R7 (%s): dat_c actual %b expected %b", req, dat_c, ~exp);
    end
  endtask

  // Drive on the falling edge, let one rising edge pass, settle on the next falling edge.
  task automatic tick(input logic g, input logic [N-1:0] pt, input logic [N-1:0] p);
    gclk_en = g;
    pterm   = pt;
    pin_in  = p;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset_latch;
    rst = 1'b1; cfg_latch = '1; cfg_async = '0;
    tick(1'b0, '0, 4'b1010);
    chk("R8 reset loads latch", 4'b1010);
    tick(1'b0, '0, 4'b0110);
    chk("R8 reset follows pin", 4'b0110);
    rst = 1'b0;
  endtask

  task automatic t_sync_reg;
    cfg_latch = '0; cfg_async = '0;
    tick(1'b1, '1, 4'b0000);
    tick(1'b0, '1, 4'b0110);
    chk("R1 capture on fall", 4'b0110);
    tick(1'b0, '0, 4'b1111);
    chk("R4 hold while low", 4'b0110);
    tick(1'b1, '0, 4'b0011);
    chk("R4 ignore rise", 4'b0110);
    tick(1'b1, '0, 4'b1001);
    chk("R4 ignore high", 4'b0110);
    tick(1'b0, '1, 4'b1100);
    chk("R1 second capture", 4'b1100);
  endtask

  task automatic t_async_reg;
    cfg_latch = '0; cfg_async = '1;
    tick(1'b0, '1, 4'b0000);
    tick(1'b1, '0, 4'b0101);
    chk("R2 capture on pterm fall", 4'b0101);
    tick(1'b0, '0, 4'b1010);
    chk("R2 global fall ignored", 4'b0101);
    tick(1'b0, 4'b0001, 4'b1010);
    tick(1'b0, 4'b0000, 4'b1110);
    chk("R9 only cell0 captures", 4'b0100);
  endtask

  task automatic t_sync_latch;
    cfg_latch = '1; cfg_async = '0;
    tick(1'b1, '0, 4'b0011);
    chk("R3 open latch", 4'b0011);
    tick(1'b1, '0, 4'b1000);
    chk("R3 transparent", 4'b1000);
    tick(1'b0, '1, 4'b0111);
    chk("R4 latch closed", 4'b1000);
    tick(1'b0, '1, 4'b0001);
    chk("R4 latch stays closed", 4'b1000);
  endtask

  task automatic t_async_latch;
    cfg_latch = '1; cfg_async = '1;
    tick(1'b1, 4'b0101, 4'b1111);
    chk("R5 per-cell open", 4'b1101);
  endtask

  task automatic t_flow;
    cfg_latch = '1; cfg_async = '1;
    tick(1'b0, '1, 4'b1001);
    chk("R6 flow-through a", 4'b1001);
    tick(1'b1, '1, 4'b0011);
    chk("R6 flow-through b", 4'b0011);
    tick(1'b0, '1, 4'b0110);
    chk("R6 flow-through c", 4'b0110);
  endtask

  task automatic t_mixed;
    // cell0 sync reg, cell1 async reg, cell2 sync latch, cell3 async latch
    cfg_latch = 4'b1100; cfg_async = 4'b1010;
    tick(1'b1, '1, 4'b1111);
    chk("R9 mixed step1", 4'b1110);
    tick(1'b0, '1, 4'b0000);
    chk("R9 mixed step2", 4'b0110);
    tick(1'b0, '0, 4'b0101);
    chk("R9 mixed step3", 4'b0100);
  endtask

  task automatic t_reset_reg;
    cfg_latch = '0; cfg_async = '0;
    tick(1'b1, '0, 4'b0000);
    tick(1'b0, '0, 4'b0011);
    chk("R1 preload", 4'b0011);
    rst = 1'b1;
    tick(1'b1, '0, 4'b1111);
    chk("R8 reg kept in reset", 4'b0011);
    rst = 1'b0;
    tick(1'b0, '0, 4'b1100);
    chk("R8 no fall after reset", 4'b0011);
  endtask

  initial begin
    rst = 1'b1; pin_in = '0; gclk_en = 1'b0; pterm = '0;
    cfg_latch = '1; cfg_async = '0;
    @(negedge clk);
    t_reset_latch();
    t_sync_reg();
    t_async_reg();
    t_sync_latch();
    t_async_latch();
    t_flow();
    t_mixed();
    t_reset_reg();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule